// File: doc/BRIEF.md
# Serial flash protect-bit update sequencer

This block runs, on the host side, the full procedure that changes the block-protect field of a serial configuration flash over a four-wire SPI link in mode 0. A single start request carries a 3-bit protect value. The block issues a write-enable command in its own chip-select frame. It then sends the write-status command with one data byte, whose protect field holds the requested value and whose other bits are zero. After that it keeps issuing read-status frames until the device reports that its self-timed internal write has finished.

The device's internal write cycle is guaranteed to end within 15 ms. The sequencer bounds the polling with a cycle counter sized from the system clock frequency and a millisecond limit. If the device still reports busy once that bound has run out, the request ends with a one-cycle error pulse instead of a done pulse. The user side sees a busy level for the whole request.

Top module: `flash_prot_seq`

## Requirements
- R1: After reset, spi_cs_no is 1, spi_sck_o is 0, and busy_o, done_o and err_o are 0.
- R2: A start_i pulse while idle is accepted, and busy_o is 1 from the following cycle. busy_o is 0 again in the cycle in which done_o or err_o pulses. A start_i seen while busy_o is 1 has no effect on the frames sent or on the result.
- R3: The first frame of a request carries exactly 8 serial clocks, and the byte sent is 8'h06 (write enable).
- R4: The second frame carries exactly 16 serial clocks: 8'h01 (write status), then a data byte with the captured protect value in bits [4:2] and zeros in bits [7:5] and [1:0]. Chip select rises right after the 16th rising edge, with no further rising edge before it.
- R5: Between consecutive frames, chip select stays high for at least 2*SCK_HALF system cycles.
- R6: The serial clock is 0 whenever chip select is high. Data out changes only while the serial clock is low. Data in is taken on the serial clock's rising edge, most significant bit first.
- R7: Every frame after the second is a read-status frame of 16 clocks starting with 8'h05. A further read-status frame follows as long as bit 0 (write in progress) of the returned status byte is 1. Status bits 7..1 do not influence the sequence.
- R8: When a returned status has bit 0 equal to 0, done_o pulses for exactly one cycle, err_o stays 0 and no further frame is sent.
- R9: If bit 0 is still 1 in a poll that ends after CLK_HZ/1000*TIMEOUT_MS cycles have passed since the write-status frame ended, err_o pulses for one cycle, done_o stays 0 and the block returns to idle. The error never comes earlier than that bound.
- R10: prot_i is captured on the accepted start. Changing it during the request does not change the byte sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse, taken when idle |
| prot_i | input | 3 | New block-protect value |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle pulse on successful completion |
| err_o | output | 1 | One-cycle pulse on poll timeout |
| spi_cs_no | output | 1 | Flash chip select, active low |
| spi_sck_o | output | 1 | Serial clock, idles low |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |

## Verification
Two things can coincide. One is the return of a read-status frame that still shows the write in progress. The other is the timeout counter reaching its bound in the same poll. At that point the block must choose error over another poll, and it must not report done. The bench provokes this by making the flash model answer busy indefinitely, then measures the time from the write-status chip-select rise to the error pulse, which must fall between the bound and one poll frame past it. It also provokes the opposite case, a busy answer that clears on the very first poll, and judges that done comes after exactly one read-status frame.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam int unsigned WIP_BIT  = 0;
  localparam int unsigned PROT_LSB = 2;
  localparam int unsigned PROT_W   = 3;

  typedef enum logic [1:0] {E_IDLE, E_SETUP, E_HI, E_GAP} eng_st_e;

  typedef enum logic [2:0] {
    S_IDLE, S_WREN, S_WREN_W, S_WRSR, S_WRSR_W, S_POLL, S_POLL_W
  } seq_st_e;
endpackage

// File: rtl/spi_frame_eng.sv
module spi_frame_eng
  import flash_prot_pkg::*;
#(
  parameter int unsigned SCK_HALF = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        two_byte_i,
  input  logic [15:0] tx_i,
  output logic        sck_o,
  output logic        cs_no,
  output logic        mosi_o,
  input  logic        miso_i,
  output logic [7:0]  rx_o,
  output logic        done_o
);
  localparam int unsigned CW  = $clog2(2 * SCK_HALF) + 1;
  localparam int unsigned GAP = 2 * SCK_HALF;

  eng_st_e        st;
  logic [CW-1:0]  cnt;
  logic [4:0]     bits, nbits;
  logic [15:0]    sh;

  assign mosi_o = sh[15];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st     <= E_IDLE;
      cnt    <= '0;
      bits   <= '0;
      nbits  <= '0;
      sh     <= '0;
      rx_o   <= '0;
      sck_o  <= 1'b0;
      cs_no  <= 1'b1;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        E_IDLE: if (start_i) begin
          sh    <= tx_i;
          nbits <= two_byte_i ? 5'd16 : 5'd8;
          bits  <= '0;
          cnt   <= '0;
          cs_no <= 1'b0;
          st    <= E_SETUP;
        end
        E_SETUP: begin
          if (cnt == CW'(SCK_HALF - 1)) begin
            cnt   <= '0;
            sck_o <= 1'b1;
            rx_o  <= {rx_o[6:0], miso_i};
            bits  <= bits + 5'd1;
            st    <= E_HI;
          end else cnt <= cnt + 1'b1;
        end
        E_HI: begin
          if (cnt == CW'(SCK_HALF - 1)) begin
            cnt   <= '0;
            sck_o <= 1'b0;
            if (bits == nbits) begin
              cs_no <= 1'b1;  // release right after last bit
              st    <= E_GAP;
            end else begin
              sh <= {sh[14:0], 1'b0};
              st <= E_SETUP;
            end
          end else cnt <= cnt + 1'b1;
        end
        E_GAP: begin
          if (cnt == CW'(GAP - 1)) begin
            cnt    <= '0;
            done_o <= 1'b1;
            st     <= E_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= E_IDLE;
      endcase
    end
  end

  // checker support: rising edges per frame, high time of chip select
  logic [4:0]    rise_cnt;
  logic [CW-1:0] hi_cnt;
  logic          sck_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_cnt <= '0;
      hi_cnt   <= CW'(GAP);
      sck_q    <= 1'b0;
    end else begin
      sck_q <= sck_o;
      if (cs_no) rise_cnt <= '0;
      else if (sck_o && !sck_q) rise_cnt <= rise_cnt + 5'd1;
      if (!cs_no) hi_cnt <= '0;
      else if (hi_cnt != CW'(GAP)) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);  // R6
  AST_MOSI_STABLE_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));  // R6
  AST_CS_RISE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> (rise_cnt == 5'd8 || rise_cnt == 5'd16));  // R4
  AST_CS_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (hi_cnt >= CW'(GAP)));  // R5
endmodule

// File: rtl/wip_timer.sv
module wip_timer #(
  parameter int unsigned LIMIT = 800
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic expired_o
);
  localparam int unsigned W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt;

  assign expired_o = (cnt >= W'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt <= '0;
    else if (clr_i) cnt <= '0;
    else if (en_i && !expired_o) cnt <= cnt + 1'b1;
  end

  AST_TMR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !clr_i) |=> expired_o);  // R9
  AST_TMR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !expired_o);  // R9
endmodule

// File: rtl/flash_prot_seq.sv
module flash_prot_seq
  import flash_prot_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 50_000_000,
  parameter int unsigned TIMEOUT_MS = 16,
  parameter int unsigned SCK_HALF   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [PROT_W-1:0] prot_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              spi_cs_no,
  output logic              spi_sck_o,
  output logic              spi_mosi_o,
  input  logic              spi_miso_i
);
  localparam int unsigned TIMEOUT_CYC = (CLK_HZ / 1000) * TIMEOUT_MS;

  seq_st_e           st;
  logic [PROT_W-1:0] prot_q;
  logic              eng_start, eng_two, eng_done;
  logic [15:0]       eng_tx;
  logic [7:0]        eng_rx;
  logic              tmr_clr, tmr_en, tmr_exp;
  logic [7:0]        wr_byte;

  assign wr_byte = 8'(prot_q) << PROT_LSB;
  assign busy_o  = (st != S_IDLE);
  assign tmr_en  = (st == S_POLL) || (st == S_POLL_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st        <= S_IDLE;
      prot_q    <= '0;
      eng_start <= 1'b0;
      eng_two   <= 1'b0;
      eng_tx    <= '0;
      tmr_clr   <= 1'b0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      eng_start <= 1'b0;
      tmr_clr   <= 1'b0;
      done_o    <= 1'b0;
      err_o     <= 1'b0;
      unique case (st)
        S_IDLE: if (start_i) begin
          prot_q <= prot_i;
          st     <= S_WREN;
        end
        S_WREN: begin
          eng_start <= 1'b1;
          eng_two   <= 1'b0;
          eng_tx    <= {OP_WREN, 8'h00};
          st        <= S_WREN_W;
        end
        S_WREN_W: if (eng_done) st <= S_WRSR;
        S_WRSR: begin
          eng_start <= 1'b1;
          eng_two   <= 1'b1;
          eng_tx    <= {OP_WRSR, wr_byte};
          st        <= S_WRSR_W;
        end
        S_WRSR_W: if (eng_done) begin
          tmr_clr <= 1'b1;
          st      <= S_POLL;
        end
        S_POLL: begin
          eng_start <= 1'b1;
          eng_two   <= 1'b1;
          eng_tx    <= {OP_RDSR, 8'h00};
          st        <= S_POLL_W;
        end
        S_POLL_W: if (eng_done) begin
          if (!eng_rx[WIP_BIT]) begin
            done_o <= 1'b1;
            st     <= S_IDLE;
          end else if (tmr_exp) begin
            err_o <= 1'b1;
            st    <= S_IDLE;
          end else st <= S_POLL;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  spi_frame_eng #(.SCK_HALF(SCK_HALF)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (eng_start),
    .two_byte_i(eng_two),
    .tx_i      (eng_tx),
    .sck_o     (spi_sck_o),
    .cs_no     (spi_cs_no),
    .mosi_o    (spi_mosi_o),
    .miso_i    (spi_miso_i),
    .rx_o      (eng_rx),
    .done_o    (eng_done)
  );

  wip_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (tmr_clr),
    .en_i     (tmr_en),
    .expired_o(tmr_exp)
  );

  AST_DONE_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));  // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R8
  AST_ERR_AFTER_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(tmr_exp));  // R9
  AST_END_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || err_o) |-> (!busy_o && spi_cs_no));  // R2
  AST_PROT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(prot_q));  // R10
endmodule

// File: tb/flash_prot_seq_tb_top.sv
module flash_prot_seq_tb_top;
  localparam int unsigned CLK_HZ = 50_000;
  localparam int unsigned TMO_MS = 16;
  localparam int unsigned HALF   = 2;
  localparam int unsigned TMO_CYC = (CLK_HZ / 1000) * TMO_MS;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] prot = '0;
  logic busy, done, err, cs_n, sck, mosi, miso = 1'b0;

  always #10 clk = ~clk;

  flash_prot_seq #(.CLK_HZ(CLK_HZ), .TIMEOUT_MS(TMO_MS), .SCK_HALF(HALF)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .prot_i(prot),
    .busy_o(busy), .done_o(done), .err_o(err),
    .spi_cs_no(cs_n), .spi_sck_o(sck), .spi_mosi_o(mosi), .spi_miso_i(miso));

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_wrsr(input logic [2:0] p);
    return {3'b000, p, 2'b00};
  endfunction

  // flash model
  int cyc = 0;
  always @(posedge clk) cyc++;
  int bitc = 0, nfr = 0, busy_left = 0;
  logic [15:0] sr = '0;
  logic [7:0] stat_out = '0;
  int fr_bits[64];
  logic [15:0] fr_val[64];
  int fr_end[64];

  always @(negedge cs_n) begin bitc = 0; sr = '0; end
  always @(posedge sck) if (!cs_n) begin
    sr = {sr[14:0], mosi};
    bitc++;
    if (bitc == 8 && sr[7:0] == 8'h05) begin
      stat_out = {8'($urandom) & 8'hFE} | ((busy_left > 0) ? 8'h01 : 8'h00);
      if (busy_left > 0) busy_left--;
    end
  end
  always @(negedge sck) if (!cs_n && bitc >= 8 && bitc < 16) miso = stat_out[15-bitc];
  always @(posedge cs_n) if (rst_n && nfr < 64) begin
    fr_bits[nfr] = bitc; fr_val[nfr] = sr; fr_end[nfr] = cyc; nfr++;
  end

  // pin discipline monitor
  int min_gap = 1 << 30, hi_run = 0, mode_err = 0;
  logic sck_p = 1'b0, mosi_p = 1'b0, cs_p = 1'b1;
  always @(negedge clk) if (rst_n) begin
    if (cs_n && sck) mode_err++;
    if (sck && sck_p && mosi != mosi_p) mode_err++;
    if (!cs_n && cs_p && hi_run < min_gap) min_gap = hi_run;
    hi_run = cs_n ? hi_run + 1 : 0;
    sck_p = sck; mosi_p = mosi; cs_p = cs_n;
  end

  task automatic run_txn(input logic [2:0] p, input int nb, input bit tmo,
                         input bit poke);
    int waited = 0;
    bit got_done = 0, got_err = 0;
    int t_end = 0, exp_fr;
    busy_left = nb; nfr = 0;
    @(negedge clk); start = 1'b1; prot = p;
    @(negedge clk); start = 1'b0; prot = ~p;  // R10 prot changed mid-request
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    repeat (30) @(negedge clk);
    if (poke) begin  // R2 start while busy
      start = 1'b1; prot = 3'(p + 1); @(negedge clk); start = 1'b0;
    end
    while (!(done || err) && waited < 5000) begin @(negedge clk); waited++; end
    got_done = done; got_err = err; t_end = cyc;
    chk(waited < 5000, "R8", "request end seen", waited, 0);
    chk(busy == 1'b0, "R2", "busy low at end pulse", busy, 0);
    @(negedge clk);
    chk(done == 1'b0 && err == 1'b0, "R8", "end pulse one cycle", {done, err}, 0);
    repeat (10) @(negedge clk);
    chk(fr_bits[0] == 8 && fr_val[0][7:0] == 8'h06, "R3", "write-enable frame",
        fr_val[0][7:0], 8'h06);
    chk(fr_bits[1] == 16, "R4", "write-status clocks", fr_bits[1], 16);
    chk(fr_val[1] == {8'h01, exp_wrsr(p)}, "R4", "write-status bytes (R10)",
        fr_val[1], {8'h01, exp_wrsr(p)});
    for (int i = 2; i < nfr; i++)
      chk(fr_bits[i] == 16 && fr_val[i][15:8] == 8'h05, "R7", "poll frame",
          fr_val[i], 16'h0500);
    if (!tmo) begin
      exp_fr = nb + 3;
      chk(got_done && !got_err, "R8", "done on clear status", {got_done, got_err}, 2);
      chk(nfr == exp_fr, "R7", "frame count", nfr, exp_fr);
    end else begin
      chk(got_err && !got_done, "R9", "error on timeout", {got_done, got_err}, 1);
      chk(t_end - fr_end[1] >= int'(TMO_CYC), "R9", "error not early",
          t_end - fr_end[1], TMO_CYC);
      chk(t_end - fr_end[1] <= int'(TMO_CYC) + 120, "R9", "error not late",
          t_end - fr_end[1], TMO_CYC);
      busy_left = 0;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sck == 1'b0, "R1", "pins in reset", {cs_n, sck}, 2);
    chk(busy == 0 && done == 0 && err == 0, "R1", "status in reset",
        {busy, done, err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run_txn(3'b101, 0, 1'b0, 1'b0);   // clears on first poll
    run_txn(3'b010, 2, 1'b0, 1'b1);   // start ignored while busy
    run_txn(3'b111, 1000, 1'b1, 1'b0); // timeout
    for (int k = 0; k < 8; k++)
      run_txn(3'($urandom_range(0, 7)), int'($urandom_range(0, 4)), 1'b0, 1'b0);
    chk(min_gap >= 2 * HALF, "R5", "min chip-select gap", min_gap, 2 * HALF);
    chk(mode_err == 0, "R6", "sck/mosi mode-0 discipline", mode_err, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule